// File: doc/BRIEF.md
# SM3 Compression Step Unit

This unit computes one step of the SM3 hash compression round on 128-bit vector operands, each holding four 32-bit lanes (lane i occupies bits 32*i+31 down to 32*i). A 3-bit opcode picks one of five operations: the SS1 helper, two TT1 forms and two TT2 forms. A 2-bit lane index picks which lane of the third operand serves as the message word for the TT1 and TT2 forms.

The arithmetic is combinational. The answer is captured in an output register on the clock edge where the input valid flag is high, and it is presented with a result valid flag one clock later. Round sequencing, round constants, message expansion and padding belong to the surrounding code and are not part of this unit. Operands are called a, b and c below, with a[i] meaning lane i of a. rol(x,n) is a 32-bit left rotate. All additions wrap modulo 2^32.

Top module: `sm3_step_unit`

## Requirements
- R1: While rst_n is low at a rising clock edge, res_data becomes all zero and res_valid becomes 0 after that edge. The reset is synchronous and active-low.
- R2: res_valid is 1 in the cycle after an edge at which in_valid was 1, and 0 in the cycle after an edge at which in_valid was 0.
- R3: Opcode 0 (SS1) gives lane 3 = rol(rol(a[3],12) + b[3] + c[3], 7), with lanes 0, 1 and 2 all zero.
- R4: For opcodes 1 to 4 the message word is c[lane_sel], where lane_sel values 0 to 3 name lanes 0 to 3.
- R5: Opcode 1 (TT1 with XOR) gives lane 3 = (a[3]^a[2]^a[1]) + a[0] + (b[3] ^ rol(a[3],12)) + word, lane 0 = a[1], lane 1 = rol(a[2],9) and lane 2 = a[3].
- R6: Opcode 2 (TT1 with majority) matches R5, except that the boolean term is (a[3]&a[2])|(a[3]&a[1])|(a[2]&a[1]).
- R7: Opcode 3 (TT2 with XOR) forms t = (a[3]^a[2]^a[1]) + a[0] + b[3] + word. Lane 3 = t ^ rol(t,9) ^ rol(t,17), lane 0 = a[1], lane 1 = rol(a[2],19) and lane 2 = a[3].
- R8: Opcode 4 (TT2 with choose) matches R7, except that the boolean term is (a[3]&a[2])|(~a[3]&a[1]).
- R9: Opcodes 5, 6 and 7 give an all-zero res_data, with res_valid still 1.
- R10: An edge at which in_valid is 0 leaves res_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation request for this cycle |
| opcode | input | 3 | Operation select (0 SS1, 1 TT1 XOR, 2 TT1 majority, 3 TT2 XOR, 4 TT2 choose) |
| lane_sel | input | 2 | Lane of op_c used as the message word |
| op_a | input | 128 | First operand, four 32-bit lanes |
| op_b | input | 128 | Second operand |
| op_c | input | 128 | Third operand |
| res_data | output | 128 | Registered result |
| res_valid | output | 1 | res_data holds a fresh result |

## Verification
Two events can land in the same cycle. A new request can be issued in the same cycle that the previous result is presented, and reset can arrive in the same cycle as a request. The bench provokes the first case with back-to-back requests whose opcodes and lane selects all differ. It provokes the second by pulling rst_n low while in_valid is high. A behavioural model predicts the output on every clock, so any result left over from an earlier request shows up as a mismatch. Reset must win over the request, and idle gaps must leave the last result in place.

// File: rtl/sm3_step_pkg.sv
// Package: shared lane geometry, opcode encoding and rotate helper for the
// SM3 step unit. Assumes 32-bit lanes, four per vector.
package sm3_step_pkg;

    localparam int LANE_W = 32;
    localparam int LANES  = 4;
    localparam int VEC_W  = LANE_W * LANES;
    localparam int SEL_W  = $clog2(LANES);

    typedef enum logic [2:0] {
        OP_SS1  = 3'd0,
        OP_TT1X = 3'd1,
        OP_TT1M = 3'd2,
        OP_TT2X = 3'd3,
        OP_TT2C = 3'd4
    } step_op_e;

    typedef enum logic [1:0] {
        BF_XOR = 2'd0,
        BF_MAJ = 2'd1,
        BF_CH  = 2'd2
    } bool_sel_e;

    function automatic logic [LANE_W-1:0] rotl(input logic [LANE_W-1:0] x, input int n);
        logic [2*LANE_W-1:0] dbl;
        dbl  = {x, x} << n;
        rotl = dbl[2*LANE_W-1:LANE_W];
    endfunction

endpackage

// File: rtl/sm3_bool_fn.sv
// Module: sm3_bool_fn
// Applies one of three bitwise boolean functions to three lane words.
// Assumes the selector is held valid for the cycle; unused codes give zero.
module sm3_bool_fn
    import sm3_step_pkg::*;
(
    input  bool_sel_e           sel,
    input  logic [LANE_W-1:0]   x,
    input  logic [LANE_W-1:0]   y,
    input  logic [LANE_W-1:0]   z,
    output logic [LANE_W-1:0]   f
);

    // Pick the boolean function per selector.
    always_comb begin
        unique case (sel)
            BF_XOR:  f = x ^ y ^ z;
            BF_MAJ:  f = (x & y) | (x & z) | (y & z);
            BF_CH:   f = (x & y) | (~x & z);
            default: f = '0;
        endcase
    end

endmodule

// File: rtl/sm3_p0.sv
// Module: sm3_p0
// SM3 P0 permutation: x xor rotl(x,9) xor rotl(x,17). Pure combinational.
module sm3_p0
    import sm3_step_pkg::*;
(
    input  logic [LANE_W-1:0] x,
    output logic [LANE_W-1:0] y
);

    // Fold the two rotated copies into the word.
    always_comb y = x ^ rotl(x, 9) ^ rotl(x, 17);

endmodule

// File: rtl/sm3_step_core.sv
// Module: sm3_step_core
// Combinational lane equations for all five step operations. Assumes
// lane i of each vector sits at bits [32*i+31:32*i]; undefined opcodes
// produce an all-zero vector.
module sm3_step_core
    import sm3_step_pkg::*;
(
    input  logic [2:0]        opcode,
    input  logic [SEL_W-1:0]  lane_sel,
    input  logic [VEC_W-1:0]  op_a,
    input  logic [VEC_W-1:0]  op_b,
    input  logic [VEC_W-1:0]  op_c,
    output logic [VEC_W-1:0]  result
);

    logic [LANE_W-1:0] a_l [LANES];
    logic [LANE_W-1:0] b_l [LANES];
    logic [LANE_W-1:0] c_l [LANES];
    logic [LANE_W-1:0] r_l [LANES];

    // Unpack and repack the lanes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign a_l[g] = op_a[g*LANE_W +: LANE_W];
        assign b_l[g] = op_b[g*LANE_W +: LANE_W];
        assign c_l[g] = op_c[g*LANE_W +: LANE_W];
        assign result[g*LANE_W +: LANE_W] = r_l[g];
    end

    step_op_e  op;
    bool_sel_e bsel;
    logic      is_tt1, is_tt2;
    logic [LANE_W-1:0] word, bterm, ss2, rot12, addend, tt_sum, ss1_sum, p0_out;

    assign op = step_op_e'(opcode);

    // Decode the opcode into function class and boolean selector.
    always_comb begin
        is_tt1 = 1'b0;
        is_tt2 = 1'b0;
        bsel   = BF_XOR;
        unique case (op)
            OP_TT1X: begin is_tt1 = 1'b1; bsel = BF_XOR; end
            OP_TT1M: begin is_tt1 = 1'b1; bsel = BF_MAJ; end
            OP_TT2X: begin is_tt2 = 1'b1; bsel = BF_XOR; end
            OP_TT2C: begin is_tt2 = 1'b1; bsel = BF_CH;  end
            default: ;
        endcase
    end

    sm3_bool_fn u_bool (
        .sel (bsel),
        .x   (a_l[3]),
        .y   (a_l[2]),
        .z   (a_l[1]),
        .f   (bterm)
    );

    // Message word, SS2 term and shared sum.
    always_comb begin
        word    = c_l[lane_sel];
        rot12   = rotl(a_l[3], 12);
        ss2     = b_l[3] ^ rot12;
        addend  = is_tt1 ? ss2 : b_l[3];
        tt_sum  = bterm + a_l[0] + addend + word;
        ss1_sum = rot12 + b_l[3] + c_l[3];
    end

    sm3_p0 u_p0 (
        .x (tt_sum),
        .y (p0_out)
    );

    // Assemble the output lanes per class.
    always_comb begin
        for (int i = 0; i < LANES; i++) r_l[i] = '0;
        if (op == OP_SS1) begin
            r_l[3] = rotl(ss1_sum, 7);
        end else if (is_tt1) begin
            r_l[0] = a_l[1];
            r_l[1] = rotl(a_l[2], 9);
            r_l[2] = a_l[3];
            r_l[3] = tt_sum;
        end else if (is_tt2) begin
            r_l[0] = a_l[1];
            r_l[1] = rotl(a_l[2], 19);
            r_l[2] = a_l[3];
            r_l[3] = p0_out;
        end
    end

endmodule

// File: rtl/sm3_step_unit.sv
// Module: sm3_step_unit (top)
// One SM3 compression step per request, registered one clock after
// in_valid. Synchronous active-low reset clears the result and its flag.
module sm3_step_unit
    import sm3_step_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        opcode,
    input  logic [1:0]        lane_sel,
    input  logic [127:0]      op_a,
    input  logic [127:0]      op_b,
    input  logic [127:0]      op_c,
    output logic [127:0]      res_data,
    output logic              res_valid
);

    logic [VEC_W-1:0] comb_res;

    sm3_step_core u_core (
        .opcode   (opcode),
        .lane_sel (lane_sel),
        .op_a     (op_a),
        .op_b     (op_b),
        .op_c     (op_c),
        .result   (comb_res)
    );

    // Capture the result on a request; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_data  <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) res_data <= comb_res;
        end
    end

endmodule

// File: rtl/sm3_step_chk.sv
// Module: sm3_step_chk
// Temporal checks on the step unit ports, bound into sm3_step_unit.
module sm3_step_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [2:0]   opcode,
    input logic [127:0] op_a,
    input logic [127:0] res_data,
    input logic         res_valid
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && res_data == '0));

    p_valid_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);

    p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);

    p_ss1_low_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 3'd0) |=> (res_data[95:0] == 96'd0));

    p_tt_shuffle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode >= 3'd1 && opcode <= 3'd4) |=>
        (res_data[31:0] == $past(op_a[63:32]) && res_data[95:64] == $past(op_a[127:96])));

    p_undef_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode > 3'd4) |=> (res_valid && res_data == '0));

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_data));

endmodule

bind sm3_step_unit sm3_step_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .op_a      (op_a),
    .res_data  (res_data),
    .res_valid (res_valid)
);

// File: tb/sim_sm3_step_unit.sv
// Bench: behavioural model of the step equations, compared every clock.
module sim_sm3_step_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [2:0]   opcode = '0;
    logic [1:0]   lane_sel = '0;
    logic [127:0] op_a = '0, op_b = '0, op_c = '0;
    logic [127:0] res_data;
    logic         res_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [127:0] exp_data = '0;
    logic         exp_valid = 1'b0;
    string        exp_tag = "R1";

    always #2 clk = ~clk;

    sm3_step_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .lane_sel(lane_sel), .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .res_data(res_data), .res_valid(res_valid)
    );

    function automatic logic [31:0] rl(input logic [31:0] v, input int n);
        logic [31:0] o;
        o = v;
        for (int k = 0; k < n; k++) o = {o[30:0], o[31]};
        return o;
    endfunction

    function automatic logic [31:0] ln(input logic [127:0] v, input int i);
        return v[i*32 +: 32];
    endfunction

    function automatic logic [127:0] model(input logic [2:0] op, input logic [1:0] s,
                                           input logic [127:0] a, input logic [127:0] b,
                                           input logic [127:0] c);
        logic [31:0] w, f, t;
        w = ln(c, int'(s));
        case (op)
            3'd0: return {rl(rl(ln(a,3),12) + ln(b,3) + ln(c,3), 7), 96'd0};
            3'd1, 3'd2: begin
                if (op == 3'd1) f = ln(a,3) ^ ln(a,2) ^ ln(a,1);
                else f = (ln(a,3)&ln(a,2)) | (ln(a,3)&ln(a,1)) | (ln(a,2)&ln(a,1));
                t = f + ln(a,0) + (ln(b,3) ^ rl(ln(a,3),12)) + w;
                return {t, ln(a,3), rl(ln(a,2),9), ln(a,1)};
            end
            3'd3, 3'd4: begin
                if (op == 3'd3) f = ln(a,3) ^ ln(a,2) ^ ln(a,1);
                else f = (ln(a,3)&ln(a,2)) | (~ln(a,3)&ln(a,1));
                t = f + ln(a,0) + ln(b,3) + w;
                return {t ^ rl(t,9) ^ rl(t,17), ln(a,3), rl(ln(a,2),19), ln(a,1)};
            end
            default: return 128'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R3";
            3'd1: return "R5 R4";
            3'd2: return "R6 R4";
            3'd3: return "R7 R4";
            3'd4: return "R8 R4";
            default: return "R9";
        endcase
    endfunction

    // Compare outputs (away from the edge), then apply the next inputs and
    // advance the model as the coming edge will.
    task automatic step(input logic r, input logic v, input logic [2:0] op,
                        input logic [1:0] s, input logic [127:0] a,
                        input logic [127:0] b, input logic [127:0] c);
        @(negedge clk);
        checks++;
        if (res_valid !== exp_valid) begin
            errors++;
            $display("FAIL %s valid: actual=%0b expected=%0b",
                     (exp_tag == "R1") ? "R1" : "R2", res_valid, exp_valid);
        end
        checks++;
        if (res_data !== exp_data) begin
            errors++;
            $display("FAIL %s data: actual=%h expected=%h", exp_tag, res_data, exp_data);
        end
        rst_n = r; in_valid = v; opcode = op; lane_sel = s;
        op_a = a; op_b = b; op_c = c;
        if (!r) begin
            exp_data = '0; exp_valid = 1'b0; exp_tag = "R1";
        end else begin
            exp_valid = v;
            if (v) begin
                exp_data = model(op, s, a, b, c);
                exp_tag  = tag_of(op);
            end else begin
                exp_tag = "R10";
            end
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        // Reset held for a few cycles with noisy inputs (R1).
        for (int i = 0; i < 3; i++) step(0, 1, 3'd1, 2'd0, rnd128(), rnd128(), rnd128());
        step(1, 0, 3'd0, 2'd0, '0, '0, '0);
        step(1, 1, 3'd0, 2'd0, '0, '0, '0);
        // Every opcode with every lane select, back to back (R3..R9).
        for (int op = 0; op < 8; op++)
            for (int s = 0; s < 4; s++)
                step(1, 1, op[2:0], s[1:0], rnd128(), rnd128(), rnd128());
        // All-ones operands to stress the wrapping sums.
        for (int op = 0; op < 5; op++) step(1, 1, op[2:0], 2'd3, '1, '1, '1);
        // Idle gap must hold data (R10) with changing inputs.
        for (int i = 0; i < 4; i++) step(1, 0, 3'd2, 2'd1, rnd128(), rnd128(), rnd128());
        // Reset in the same cycle as a request (R1 wins).
        step(1, 1, 3'd4, 2'd2, rnd128(), rnd128(), rnd128());
        step(0, 1, 3'd4, 2'd2, rnd128(), rnd128(), rnd128());
        step(1, 1, 3'd3, 2'd1, rnd128(), rnd128(), rnd128());
        // Random traffic with random gaps.
        for (int i = 0; i < 600; i++)
            step(($urandom % 50) != 0, $urandom % 2, 3'($urandom % 8), 2'($urandom % 4),
                 rnd128(), rnd128(), rnd128());
        step(1, 0, 3'd0, 2'd0, '0, '0, '0);
        step(1, 0, 3'd0, 2'd0, '0, '0, '0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule